// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block puts a bank of configuration registers behind a two-address, byte-wide I/O port. The lower address is the index port and the address above it is the data port. At reset the port is locked. A host unlocks it by writing a fixed four-byte key to the index port. While unlocked, the host writes a register index to the index port and then reads or writes that register through the data port.

A selector register picks which logical device's register bank appears at the upper indices. Each device has an activation bit and a 16-bit base address, and both are exported as ports so that the device logic elsewhere on the chip can decode its own function. Read-only identity registers report a 16-bit chip number and a 4-bit revision. Writing a dedicated exit command locks the port again.

The key matcher is a five-state machine. `ST_KEY0` waits for the first key byte. `ST_KEY1`, `ST_KEY2` and `ST_KEY3` have each accepted one more key byte. `ST_OPEN` is the unlocked state. The transitions are as follows:
- `adv`: a correct key byte written to the index port moves the machine one step forward; the step from `ST_KEY3` enters `ST_OPEN`.
- `restart`: a wrong byte returns the machine to `ST_KEY0`, or to `ST_KEY1` when that byte is the first key byte.
- `hold`: any access other than an index-port write leaves the state unchanged.
- `relock`: the exit command moves `ST_OPEN` to `ST_KEY0`.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the port is locked, every activation bit and base address is zero, and `io_rdata` is 0xFF.
- R2: Writing the bytes 0x87, 0x01, 0x55, 0x55 in that order to the index port (`BASE_ADDR`) unlocks the port. Writes to the data port and reads of any address do not advance or reset the key matcher.
- R3: While locked, an index-port byte that does not match the next key byte restarts the matcher. If that byte is 0x87 it counts as the first key byte, otherwise the matcher returns to its first step. A full correct key sent after a broken one still unlocks.
- R4: While locked, writes to the data port change nothing, and data-port reads return 0xFF.
- R5: While unlocked, an index-port write selects a register and the data port (`BASE_ADDR`+1) reads or writes it. Read data appears on `io_rdata` in the cycle after the read strobe and holds until the next read.
- R6: Index 0x07 is the logical-device selector. It is a full byte that reads back what was written, and it chooses the bank seen at indices 0x30 and above.
- R7: Index 0x20 reads `CHIP_ID[15:8]`, index 0x21 reads `CHIP_ID[7:0]`, and index 0x22 reads the revision in bits 3:0 with zero in bits 7:4. Writes to these three indices have no effect.
- R8: Index 0x30 is the selected device's activation register. Bit 0 is stored, drives `dev_active[selector]` and reads back in bit 0 with zeros above it.
- R9: Index 0x60 holds the high byte and index 0x61 the low byte of the selected device's base address. The address is exported on `dev_base[16*d +: 16]` for device d.
- R10: A data write of 0x02 while the index is 0x02 relocks the port, and the full key is then needed again. Any other value written at index 0x02 leaves the port unlocked.
- R11: When the selector is `N_DEV` or larger, reads of indices 0x30, 0x60 and 0x61 return 0xFF and writes to them are ignored. Indices that are not implemented also read 0xFF.
- R12: Accesses to addresses other than the index and data ports are ignored, and reads of them return 0xFF. Reads of the index port also return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| dev_active | output | N_DEV | Activation bit per logical device |
| dev_base | output | 16*N_DEV | Base address per logical device |

## Verification
Directed sequences cover the complete key, a key broken after three correct bytes, a key broken by a repeated first byte, and the exit index written first with a wrong value and then with the exit command. Together these separate a matcher that restarts correctly from one that sticks, skips a step or relocks on any write at index 0x02. Constrained random traffic then mixes index bytes drawn from the key and register values, selector values both inside and beyond the device count, stray addresses, and reads and writes at both ports. A bench model predicts every read and every exported device register. This separates correct bank steering by the selector from writes that land in the wrong device or slip through while the port is locked.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    typedef enum logic [2:0] {
        ST_KEY0,
        ST_KEY1,
        ST_KEY2,
        ST_KEY3,
        ST_OPEN
    } key_state_t;

    localparam logic [7:0] KEY_B0 = 8'h87;
    localparam logic [7:0] KEY_B1 = 8'h01;
    localparam logic [7:0] KEY_B2 = 8'h55;
    localparam logic [7:0] KEY_B3 = 8'h55;

    localparam logic [7:0] IDX_EXIT    = 8'h02;
    localparam logic [7:0] IDX_SEL     = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;

    localparam logic [7:0] EXIT_CMD  = 8'h02;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       exit_req,
    output logic       unlocked
);
    key_state_t state_q;
    key_state_t state_d;
    key_state_t restart;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_KEY0;
        else        state_q <= state_d;
    end

    // A byte that breaks the key may itself be the first key byte
    always_comb begin
        restart = (key_byte == KEY_B0) ? ST_KEY1 : ST_KEY0;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_KEY0: if (key_wr) state_d = (key_byte == KEY_B0) ? ST_KEY1 : ST_KEY0;
            ST_KEY1: if (key_wr) state_d = (key_byte == KEY_B1) ? ST_KEY2 : restart;
            ST_KEY2: if (key_wr) state_d = (key_byte == KEY_B2) ? ST_KEY3 : restart;
            ST_KEY3: if (key_wr) state_d = (key_byte == KEY_B3) ? ST_OPEN : restart;
            ST_OPEN: if (exit_req) state_d = ST_KEY0;
            default: state_d = ST_KEY0;
        endcase
    end

    // Outputs
    always_comb begin
        unlocked = (state_q == ST_OPEN);
    end
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
    import cfgp_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            sel,
    input  logic [7:0]            idx,
    input  logic [7:0]            wdata,
    output logic [N_DEV-1:0]      act,
    output logic [16*N_DEV-1:0]   base,
    output logic [7:0]            rd_byte
);
    localparam int SEL_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam logic [8:0] N_DEV_L = 9'(N_DEV);

    logic        act_q  [N_DEV];
    logic [15:0] base_q [N_DEV];
    logic        sel_ok;
    logic [SEL_W-1:0] sel_i;

    always_comb begin
        sel_ok = ({1'b0, sel} < N_DEV_L);
        sel_i  = sel[SEL_W-1:0];
    end

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q[g]  <= 1'b0;
                base_q[g] <= 16'h0000;
            end else if (wr_en && (sel == 8'(g))) begin
                case (idx)
                    IDX_ACT:     act_q[g]        <= wdata[0];
                    IDX_BASE_HI: base_q[g][15:8] <= wdata;
                    IDX_BASE_LO: base_q[g][7:0]  <= wdata;
                    default: ;
                endcase
            end
        end
        assign act[g]          = act_q[g];
        assign base[16*g +: 16] = base_q[g];
    end

    always_comb begin
        rd_byte = IDLE_BYTE;
        if (sel_ok) begin
            case (idx)
                IDX_ACT:     rd_byte = {7'b0, act_q[sel_i]};
                IDX_BASE_HI: rd_byte = base_q[sel_i][15:8];
                IDX_BASE_LO: rd_byte = base_q[sel_i][7:0];
                default:     rd_byte = IDLE_BYTE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfgp_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
    parameter int              N_DEV     = 4,
    parameter logic [15:0]     CHIP_ID   = 16'h8716,
    parameter logic [3:0]      CHIP_REV  = 4'h3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    output logic [N_DEV-1:0]    dev_active,
    output logic [16*N_DEV-1:0] dev_base
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    logic       unlocked;
    logic       idx_hit, dat_hit;
    logic       key_wr, exit_req, dat_wr;
    logic [7:0] index_q, sel_q, rdata_q;
    logic [7:0] bank_byte, rd_mux;

    always_comb begin
        idx_hit  = (io_addr == BASE_ADDR);
        dat_hit  = (io_addr == DATA_ADDR);
        key_wr   = io_wr && idx_hit && !unlocked;
        dat_wr   = io_wr && dat_hit && unlocked;
        exit_req = dat_wr && (index_q == IDX_EXIT) && (io_wdata == EXIT_CMD);
    end

    cfgp_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (io_wdata),
        .exit_req (exit_req),
        .unlocked (unlocked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
            sel_q   <= 8'h00;
        end else begin
            if (io_wr && idx_hit && unlocked) index_q <= io_wdata;
            if (dat_wr && (index_q == IDX_SEL)) sel_q <= io_wdata;
        end
    end

    cfgp_regbank #(.N_DEV(N_DEV)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dat_wr),
        .sel     (sel_q),
        .idx     (index_q),
        .wdata   (io_wdata),
        .act     (dev_active),
        .base    (dev_base),
        .rd_byte (bank_byte)
    );

    always_comb begin
        rd_mux = IDLE_BYTE;
        if (unlocked && dat_hit) begin
            case (index_q)
                IDX_SEL:   rd_mux = sel_q;
                IDX_ID_HI: rd_mux = CHIP_ID[15:8];
                IDX_ID_LO: rd_mux = CHIP_ID[7:0];
                IDX_REV:   rd_mux = {4'h0, CHIP_REV};
                default:   rd_mux = (index_q >= IDX_ACT) ? bank_byte : IDLE_BYTE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= IDLE_BYTE;
        else if (io_rd) rdata_q <= rd_mux;
    end

    assign io_rdata = rdata_q;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
    parameter int                N_DEV     = 4,
    parameter logic [15:0]       CHIP_ID   = 16'h8716
) (
    input logic                clk,
    input logic                rst_n,
    input logic                io_wr,
    input logic                io_rd,
    input logic [ADDR_W-1:0]   io_addr,
    input logic [7:0]          io_wdata,
    input logic [7:0]          io_rdata,
    input logic [N_DEV-1:0]    dev_active,
    input logic [16*N_DEV-1:0] dev_base,
    input logic                unlocked,
    input logic [7:0]          index_q
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    assert_unlock_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(io_wr && io_addr == BASE_ADDR && io_wdata == 8'h55));

    assert_locked_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_wr && io_addr == DATA_ADDR) |=> ($stable(dev_active) && $stable(dev_base)));

    assert_locked_read_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_rd) |=> (io_rdata == 8'hFF));

    assert_id_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && io_rd && io_addr == DATA_ADDR && index_q == 8'h20) |=> (io_rdata == CHIP_ID[15:8]));

    assert_dev_only_on_data_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == DATA_ADDR) |=> ($stable(dev_active) && $stable(dev_base)));

    assert_exit_relocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && io_wr && io_addr == DATA_ADDR && index_q == 8'h02 && io_wdata == 8'h02) |=> !unlocked);

    assert_stray_read_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr != DATA_ADDR) |=> (io_rdata == 8'hFF));
endmodule

bind cfg_port_ctrl cfgp_checker #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .N_DEV(N_DEV), .CHIP_ID(CHIP_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_active(dev_active),
    .dev_base(dev_base), .unlocked(unlocked), .index_q(index_q)
);

// File: tb/tb_cfg_port_ctrl.sv
module tb_cfg_port_ctrl;
    localparam int          CLK_P   = 10;
    localparam int          N_DEV   = 4;
    localparam logic [15:0] BASE    = 16'h002E;
    localparam logic [15:0] DATA    = 16'h002F;
    localparam logic [15:0] CHIP_ID = 16'h8716;
    localparam logic [3:0]  REV     = 4'h3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                io_wr = 1'b0;
    logic                io_rd = 1'b0;
    logic [15:0]         io_addr = 16'h0;
    logic [7:0]          io_wdata = 8'h0;
    logic [7:0]          io_rdata;
    logic [N_DEV-1:0]    dev_active;
    logic [16*N_DEV-1:0] dev_base;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model
    int          m_step;
    logic [7:0]  m_idx, m_sel;
    logic        m_act  [N_DEV];
    logic [15:0] m_base [N_DEV];

    cfg_port_ctrl #(.ADDR_W(16), .BASE_ADDR(BASE), .N_DEV(N_DEV),
                    .CHIP_ID(CHIP_ID), .CHIP_REV(REV)) dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_active(dev_active), .dev_base(dev_base)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] key_byte(input int s);
        case (s)
            0: return 8'h87;
            1: return 8'h01;
            default: return 8'h55;
        endcase
    endfunction

    task automatic m_write(input logic [15:0] a, input logic [7:0] d);
        if (a == BASE) begin
            if (m_step < 4) begin
                if (d == key_byte(m_step)) m_step++;
                else m_step = (d == 8'h87) ? 1 : 0;
            end else m_idx = d;
        end else if (a == DATA && m_step == 4) begin
            case (m_idx)
                8'h02: if (d == 8'h02) m_step = 0;
                8'h07: m_sel = d;
                8'h30: if (m_sel < N_DEV) m_act[m_sel] = d[0];
                8'h60: if (m_sel < N_DEV) m_base[m_sel][15:8] = d;
                8'h61: if (m_sel < N_DEV) m_base[m_sel][7:0] = d;
                default: ;
            endcase
        end
    endtask

    function automatic logic [7:0] m_read(input logic [15:0] a);
        if (a != DATA || m_step != 4) return 8'hFF;
        case (m_idx)
            8'h07: return m_sel;
            8'h20: return CHIP_ID[15:8];
            8'h21: return CHIP_ID[7:0];
            8'h22: return {4'h0, REV};
            8'h30: return (m_sel < N_DEV) ? {7'b0, m_act[m_sel]} : 8'hFF;
            8'h60: return (m_sel < N_DEV) ? m_base[m_sel][15:8] : 8'hFF;
            8'h61: return (m_sel < N_DEV) ? m_base[m_sel][7:0] : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check_devs(input string tag);
        logic [N_DEV-1:0]    ea;
        logic [16*N_DEV-1:0] eb;
        for (int i = 0; i < N_DEV; i++) begin
            ea[i] = m_act[i];
            eb[16*i +: 16] = m_base[i];
        end
        check({tag, " act"}, 32'(dev_active), 32'(ea));
        for (int i = 0; i < N_DEV; i++)
            check({tag, " base"}, 32'(dev_base[16*i +: 16]), 32'(eb[16*i +: 16]));
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        m_write(a, d);
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        logic [7:0] e;
        e = m_read(a);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        @(negedge clk);
        io_rd = 1'b0;
        check(tag, 32'(io_rdata), 32'(e));
    endtask

    task automatic unlock();
        wr(BASE, 8'h87); wr(BASE, 8'h01); wr(BASE, 8'h55); wr(BASE, 8'h55);
    endtask

    task automatic reg_rd(input logic [7:0] i, input logic [7:0] exp, input string tag);
        wr(BASE, i);
        rd(DATA, tag);
        check({tag, " const"}, 32'(io_rdata), 32'(exp));
    endtask

    initial begin
        m_step = 0; m_idx = 8'h0; m_sel = 8'h0;
        for (int i = 0; i < N_DEV; i++) begin m_act[i] = 1'b0; m_base[i] = 16'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", 32'(io_rdata), 32'hFF);
        check_devs("R1");
        // R4 locked port
        wr(DATA, 8'h07); wr(DATA, 8'h01);
        rd(DATA, "R4 locked read");
        check_devs("R4");
        // R3 broken key, then a key that starts with a repeated first byte
        wr(BASE, 8'h87); wr(BASE, 8'h01); wr(BASE, 8'h55); wr(BASE, 8'h12);
        wr(DATA, 8'h55);  // data writes do not feed the matcher (R2)
        rd(DATA, "R3 still locked");
        check("R3 locked", 32'(io_rdata), 32'hFF);
        wr(BASE, 8'h87); wr(BASE, 8'h87); wr(BASE, 8'h01); wr(BASE, 8'h55); wr(BASE, 8'h55);
        reg_rd(8'h20, 8'h87, "R3 R7 id high after retry");
        reg_rd(8'h21, 8'h16, "R7 id low");
        reg_rd(8'h22, 8'h03, "R7 revision");
        // R7 identity write ignored
        wr(BASE, 8'h20); wr(DATA, 8'h00);
        rd(DATA, "R7 id write ignored");
        check("R7 id unchanged", 32'(io_rdata), 32'h87);
        // R6 R8 R9 bank access
        wr(BASE, 8'h07); wr(DATA, 8'h01);
        reg_rd(8'h07, 8'h01, "R6 selector");
        wr(BASE, 8'h30); wr(DATA, 8'hFF);
        wr(BASE, 8'h60); wr(DATA, 8'h12);
        wr(BASE, 8'h61); wr(DATA, 8'h34);
        check("R8 dev1 active", 32'(dev_active), 32'h2);
        check("R9 dev1 base", 32'(dev_base[31:16]), 32'h1234);
        reg_rd(8'h30, 8'h01, "R8 act readback");
        reg_rd(8'h60, 8'h12, "R9 base high");
        reg_rd(8'h61, 8'h34, "R5 R9 base low");
        // R11 selector beyond the devices
        wr(BASE, 8'h07); wr(DATA, 8'h09);
        wr(BASE, 8'h30); wr(DATA, 8'h01);
        rd(DATA, "R11 out of range");
        check_devs("R11");
        reg_rd(8'h45, 8'hFF, "R11 unimplemented");
        // R12 stray address and index-port read
        wr(16'h0080, 8'h55);
        rd(16'h0080, "R12 stray read");
        rd(BASE, "R12 index read");
        // R10 exit
        wr(BASE, 8'h02); wr(DATA, 8'h05);
        reg_rd(8'h21, 8'h16, "R10 wrong exit value");
        wr(BASE, 8'h02); wr(DATA, 8'h02);
        rd(DATA, "R10 relocked");
        check("R10 relocked const", 32'(io_rdata), 32'hFF);
        // Random traffic
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0] b;
            if (n % 60 == 0) unlock();
            op = $urandom_range(0, 9);
            case ($urandom_range(0, 11))
                0: b = 8'h87; 1: b = 8'h01; 2: b = 8'h55; 3: b = 8'h02;
                4: b = 8'h07; 5: b = 8'h20; 6: b = 8'h22; 7: b = 8'h30;
                8: b = 8'h60; 9: b = 8'h61; 10: b = 8'($urandom_range(0, 5));
                default: b = 8'($urandom);
            endcase
            if (op < 3)      wr(BASE, b);
            else if (op < 6) wr(DATA, b);
            else if (op < 9) rd(DATA, "R5 random read");
            else if (b[0])   wr(16'h0040, b);
            else             rd(16'h0040, "R12 random stray");
            check_devs("R9 random");
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule